// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block sequences one access at a time on an 8051-style external memory bus. The bus carries the low address byte and the data byte on one shared 8-bit port, with the high address byte on a separate port. It produces the address latch strobe, an active-low program fetch strobe and active-low read and write strobes. It drives the shared port with the low address while the latch strobe is high. It then three-states the port to capture read data, or drives write data onto it.

The block runs on a timebase at twice the oscillator rate, so each clock is half an oscillator period. A full bus cycle is 8 ticks (four oscillator periods), and the latch strobe is high for the first 3 of them (1.5 periods). A request is taken only while `ready` is high. A one-tick `done` marks the end of every access.

In page mode the block keeps a program page open after a fetch. A later fetch whose high address byte matches the open page skips the address phase. It takes only the 4 strobe ticks, and the fetch strobe stays low between such fetches. While the bus is idle, the latch strobe either toggles freely, is held high for EMI reduction, or stays low, depending on the mode inputs.

Top module: `xbus_seq`

## Requirements
- R1: During and right after reset, `ale` is 1, `psenN`, `rdN` and `wrN` are 1, `adOe` is 0 and `ready` is 1.
- R2: A request is accepted at a rising edge where `reqValid` and `ready` are both 1. A full cycle then lasts 8 ticks, numbered 0 to 7. In ticks 0 to 2 `ale` is 1 and the shared port drives the low address byte (`adOe`=1). From tick 3 on, `ale` is 0.
- R3: `reqKind` 00 is a fetch, 01 a read, and 1x a write. In ticks 4 to 7 exactly one strobe is low: `psenN` for a fetch, `rdN` for a read, `wrN` for a write. `psenN` is never low for a read or a write.
- R4: For a fetch or a read, `rdData` takes the value on `adIn` at the edge that ends the last strobe tick. During the strobe ticks `adOe` is 0.
- R5: For a write, the port drives the write data (`adOe`=1) from tick 3 through tick 7.
- R6: `addrHi` shows the request's high address byte from tick 0 to the end of the access and does not change during it.
- R7: `done` is 1 for exactly the one tick after the last strobe tick, and `ready` is 1 in that tick. A request presented while `ready` is 0 is ignored: it changes neither the address, the data nor the timing of the access in progress.
- R8: When `pageMode` is 1 and a fetch has completed, the page stays open. A fetch whose high byte equals the open page's byte then runs only ticks 4 to 7: `ale` stays 0 and `psenN` stays low from the end of the previous fetch through this one.
- R9: A fetch with a different high byte, any read or write, or clearing `pageMode` closes the page. The next fetch then runs a full 8-tick cycle with its address phase, and `psenN` is high in ticks 0 to 3.
- R10: While idle, `ale` is 1 if `emiReduce` is 1. Otherwise, if `aleEnable` is 1, it toggles with period 8, high for 3 ticks. Otherwise it is 0.
- R11: `adWeakHi` flags the driven port bits that are 1 (only weakly pulled up). It equals `adOut` while `adOe` is 1 and is all zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase at twice the oscillator rate |
| rst | input | 1 | Synchronous active-high reset |
| aleEnable | input | 1 | Let `ale` toggle while idle |
| emiReduce | input | 1 | Hold `ale` high while idle |
| pageMode | input | 1 | Enable page-hit fetches |
| reqValid | input | 1 | Access request |
| reqKind | input | 2 | 00 fetch, 01 read, 1x write |
| reqAddr | input | 16 | Access address |
| reqWdata | input | 8 | Write data |
| adIn | input | 8 | Value seen on the shared port |
| ready | output | 1 | Sequencer idle, request may be accepted |
| done | output | 1 | Access finished (one tick) |
| rdData | output | 8 | Captured read or fetch data |
| ale | output | 1 | Address latch strobe |
| psenN | output | 1 | Active-low program fetch strobe |
| rdN | output | 1 | Active-low data read strobe |
| wrN | output | 1 | Active-low data write strobe |
| addrHi | output | 8 | High address byte port |
| adOut | output | 8 | Value driven on the shared port |
| adOe | output | 1 | Shared port output enable |
| adWeakHi | output | 8 | Driven bits that are 1 (weak pull-up only) |

## Verification
The bench counts edges from the accept edge E0. Tick k of an access is the cycle that follows edge E(k), so the bench samples every strobe, `adOut` and `addrHi` at the falling edge inside that tick, with the tick number shifted by 4 for page hits. `rdData` is registered at edge E8, or E4 for a hit, and `done` rises at that same edge. Both are therefore checked at the next falling edge, and `done`'s return to 0 is checked one tick later. The idle `ale` pattern is checked over 16 consecutive ticks for its high count and its period of 8, not for a phase.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [1:0] {
    KIND_FETCH = 2'b00,
    KIND_READ  = 2'b01,
    KIND_WRITE = 2'b10
  } busKind_e;

  // strobes from the control to the datapath
  typedef struct packed {
    logic busy;       // an access is running
    logic latch;      // load request registers this edge
    logic addrPhase;  // drive low address byte
    logic dataPhase;  // drive write data
    logic capture;    // sample read data this edge
  } busStrobes_t;
endpackage

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int CYCLE_TICKS = 8,
  parameter int ALE_TICKS   = 3,
  parameter int STROBE_AT   = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        aleEnable,
  input  logic        emiReduce,
  input  logic        pageMode,
  input  logic        reqValid,
  input  logic [1:0]  reqKind,
  input  logic        hiMatch,
  output logic        ready,
  output logic        done,
  output logic        ale,
  output logic        psenN,
  output logic        rdN,
  output logic        wrN,
  output busStrobes_t strb
);
  localparam int PH_W = $clog2(CYCLE_TICKS);
  localparam logic [PH_W-1:0] PH_LAST  = PH_W'(CYCLE_TICKS - 1);
  localparam logic [PH_W-1:0] PH_ALE   = PH_W'(ALE_TICKS);
  localparam logic [PH_W-1:0] PH_STRB  = PH_W'(STROBE_AT);

  logic            busy;
  logic [PH_W-1:0] ph;
  logic [PH_W-1:0] freeTick;
  busKind_e        kindR;
  busKind_e        kindIn;
  logic            pageOpen;
  logic            accept;
  logic            pageHit;
  logic            lastTick;
  logic            idleAle;

  assign kindIn   = reqKind[1] ? KIND_WRITE : (reqKind[0] ? KIND_READ : KIND_FETCH);
  assign accept   = reqValid && !busy;
  assign pageHit  = pageMode && pageOpen && (kindIn == KIND_FETCH) && hiMatch;
  assign lastTick = busy && (ph == PH_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      ph       <= '0;
      kindR    <= KIND_FETCH;
      pageOpen <= 1'b0;
      done     <= 1'b0;
      freeTick <= '0;
    end else begin
      done     <= 1'b0;
      freeTick <= (freeTick == PH_LAST) ? '0 : freeTick + 1'b1;
      if (accept) begin
        busy  <= 1'b1;
        kindR <= kindIn;
        ph    <= pageHit ? PH_STRB : '0;
        if (!pageHit) pageOpen <= 1'b0;
      end else if (busy) begin
        if (lastTick) begin
          busy <= 1'b0;
          done <= 1'b1;
          if (kindR == KIND_FETCH && pageMode) pageOpen <= 1'b1;
        end else begin
          ph <= ph + 1'b1;
        end
      end
      if (!pageMode) pageOpen <= 1'b0;
    end
  end

  always_comb begin
    strb.busy      = busy;
    strb.latch     = accept;
    strb.addrPhase = busy && (ph < PH_ALE);
    strb.dataPhase = busy && (kindR == KIND_WRITE) && (ph >= PH_ALE);
    strb.capture   = lastTick && (kindR != KIND_WRITE);
  end

  assign idleAle = emiReduce ? 1'b1 : (aleEnable && (freeTick < PH_ALE));
  assign ale     = rst ? 1'b1 : (busy ? (ph < PH_ALE) : idleAle);
  assign psenN   = !((busy && kindR == KIND_FETCH && ph >= PH_STRB) ||
                     (!busy && pageOpen && pageMode));
  assign rdN     = !(busy && kindR == KIND_READ  && ph >= PH_STRB);
  assign wrN     = !(busy && kindR == KIND_WRITE && ph >= PH_STRB);
  assign ready   = !busy;

  // R7: done lasts one tick
  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R3: never two strobes low together
  p_one_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    $countones({!psenN, !rdN, !wrN}) <= 1);
  // R4: done follows a strobe tick
  p_done_after_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(!psenN || !rdN || !wrN));
  // R8: a page hit has no address phase
  p_hit_no_ale_r8: assert property (@(posedge clk) disable iff (rst)
    (accept && pageHit) |=> (!ale && !psenN));
endmodule

// File: rtl/xbus_dpath.sv
module xbus_dpath
  import xbus_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  busStrobes_t       strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] adIn,
  output logic              hiMatch,
  output logic [ADDR_W-DATA_W-1:0] addrHi,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] adOut,
  output logic              adOe,
  output logic [DATA_W-1:0] adWeakHi
);
  localparam int HI_W = ADDR_W - DATA_W;

  logic [DATA_W-1:0] loReg;
  logic [HI_W-1:0]   hiReg;
  logic [DATA_W-1:0] wdReg;
  logic [DATA_W-1:0] rdReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      loReg <= '0;
      hiReg <= '0;
      wdReg <= '0;
      rdReg <= '0;
    end else begin
      if (strb.latch) begin
        loReg <= reqAddr[DATA_W-1:0];
        hiReg <= reqAddr[ADDR_W-1:DATA_W];
        wdReg <= reqWdata;
      end
      if (strb.capture) rdReg <= adIn;
    end
  end

  assign hiMatch  = (reqAddr[ADDR_W-1:DATA_W] == hiReg);
  assign addrHi   = hiReg;
  assign rdData   = rdReg;
  assign adOe     = strb.addrPhase || strb.dataPhase;
  assign adOut    = strb.addrPhase ? loReg : (strb.dataPhase ? wdReg : '0);
  assign adWeakHi = adOut & {DATA_W{adOe}};

  // R6: high byte steady while an access runs
  p_hi_stable_r6: assert property (@(posedge clk) disable iff (rst)
    (strb.busy && $past(strb.busy)) |-> $stable(addrHi));
  // R4: port released while read data is sampled
  p_release_on_capture_r4: assert property (@(posedge clk) disable iff (rst)
    strb.capture |-> !adOe);
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 16,
  parameter int CYCLE_TICKS = 8,
  parameter int ALE_TICKS   = 3,
  parameter int STROBE_AT   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              aleEnable,
  input  logic              emiReduce,
  input  logic              pageMode,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] adIn,
  output logic              ready,
  output logic              done,
  output logic [DATA_W-1:0] rdData,
  output logic              ale,
  output logic              psenN,
  output logic              rdN,
  output logic              wrN,
  output logic [ADDR_W-DATA_W-1:0] addrHi,
  output logic [DATA_W-1:0] adOut,
  output logic              adOe,
  output logic [DATA_W-1:0] adWeakHi
);
  busStrobes_t strb;
  logic        hiMatch;

  xbus_ctrl #(
    .CYCLE_TICKS(CYCLE_TICKS), .ALE_TICKS(ALE_TICKS), .STROBE_AT(STROBE_AT)
  ) u_ctrl (
    .clk(clk), .rst(rst), .aleEnable(aleEnable), .emiReduce(emiReduce),
    .pageMode(pageMode), .reqValid(reqValid), .reqKind(reqKind),
    .hiMatch(hiMatch), .ready(ready), .done(done), .ale(ale),
    .psenN(psenN), .rdN(rdN), .wrN(wrN), .strb(strb)
  );

  xbus_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rst(rst), .strb(strb), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .adIn(adIn), .hiMatch(hiMatch), .addrHi(addrHi),
    .rdData(rdData), .adOut(adOut), .adOe(adOe), .adWeakHi(adWeakHi)
  );
endmodule

// File: tb/tb_xbus_seq.sv
module tb_xbus_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        aleEnable = 1'b0, emiReduce = 1'b0, pageMode = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqKind = 2'b00;
  logic [15:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0, adIn = '0;
  logic        ready, done, ale, psenN, rdN, wrN, adOe;
  logic [7:0]  rdData, addrHi, adOut, adWeakHi;

  int checks = 0;
  int errors = 0;
  bit bOpen = 0;
  logic [7:0] bHi = '0;

  always #5 clk = ~clk;

  xbus_seq dut (
    .clk(clk), .rst(rst), .aleEnable(aleEnable), .emiReduce(emiReduce),
    .pageMode(pageMode), .reqValid(reqValid), .reqKind(reqKind),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .adIn(adIn), .ready(ready),
    .done(done), .rdData(rdData), .ale(ale), .psenN(psenN), .rdN(rdN),
    .wrN(wrN), .addrHi(addrHi), .adOut(adOut), .adOe(adOe),
    .adWeakHi(adWeakHi)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one access; kind 0 fetch, 1 read, 2 write
  task automatic runAccess(input int kind, input logic [15:0] addr,
                           input logic [7:0] wd, input logic [7:0] din,
                           input bit tamper);
    bit hit;
    int n;
    hit = pageMode && bOpen && kind == 0 && addr[15:8] == bHi;
    n = hit ? 4 : 8;
    @(negedge clk);
    check("R7 done back to 0", done, 0);
    check("R7 ready idle", ready, 1);
    reqValid = 1'b1;
    reqKind  = 2'(kind);
    reqAddr  = addr;
    reqWdata = wd;
    adIn     = din;
    @(posedge clk);
    bHi = addr[15:8];
    if (!hit) bOpen = 0;
    for (int k = 0; k < n; k++) begin
      int ph;
      logic [4:0] expS;
      logic expOe;
      logic [7:0] expOut;
      @(negedge clk);
      if (k == 0) begin
        if (tamper) begin
          reqAddr = ~addr;
          reqWdata = ~wd;
        end else begin
          reqValid = 1'b0;
        end
      end
      ph = hit ? 4 + k : k;
      expOe  = (ph < 3) || (kind == 2 && ph >= 3);
      expOut = (ph < 3) ? addr[7:0] : ((kind == 2) ? wd : 8'h00);
      expS = {ph < 3, !(kind == 0 && ph >= 4), !(kind == 1 && ph >= 4),
              !(kind == 2 && ph >= 4), expOe};
      check(hit ? "R8 page-hit strobes" : "R2 R3 R5 strobes",
            {ale, psenN, rdN, wrN, adOe}, expS);
      if (expOe) check("R2 R5 port value", adOut, expOut);
      check("R11 weak-high bits", adWeakHi, expOe ? expOut : 8'h00);
      check("R6 high byte held", addrHi, addr[15:8]);
      check("R7 busy not ready", ready, 0);
    end
    @(negedge clk);
    reqValid = 1'b0;
    check("R7 done pulse", done, 1);
    check("R7 ready at done", ready, 1);
    if (kind != 2) check("R4 read capture", rdData, din);
    check("R8 psen held after fetch", psenN, !(pageMode && kind == 0));
    if (kind == 0 && pageMode) bOpen = 1;
  endtask

  initial begin
    #(10 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic samples [16];
    int highs;
    repeat (3) @(negedge clk);
    check("R1 reset strobes", {ale, psenN, rdN, wrN, adOe}, 5'b11110);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset ready", {ready, psenN, rdN, wrN, adOe}, 5'b11110);

    // sweep of kinds and addresses, page mode off
    for (int kind = 0; kind < 3; kind++)
      for (int i = 0; i < 8; i++)
        runAccess(kind, 16'(i * 16'h2345 + 16'h0011), 8'(i * 37 + 5),
                  8'(8'hA5 ^ (i * 19)), 1'b0);

    // ignored request during a busy access
    runAccess(1, 16'h5A3C, 8'h00, 8'h6E, 1'b1);
    runAccess(2, 16'hC30F, 8'h81, 8'h00, 1'b1);

    // page mode sequence
    pageMode = 1'b1;
    runAccess(0, 16'h1234, 8'h00, 8'h11, 1'b0); // first fetch: full
    runAccess(0, 16'h1256, 8'h00, 8'h22, 1'b0); // R8 hit
    runAccess(0, 16'h12FF, 8'h00, 8'h33, 1'b0); // R8 hit
    runAccess(0, 16'h1300, 8'h00, 8'h44, 1'b0); // R9 miss
    runAccess(0, 16'h1301, 8'h00, 8'h55, 1'b0); // hit
    runAccess(1, 16'h1302, 8'h00, 8'h66, 1'b0); // R9 data access
    runAccess(0, 16'h1303, 8'h00, 8'h77, 1'b0); // R9 full after data
    runAccess(2, 16'h1304, 8'h9C, 8'h00, 1'b0); // write closes page
    runAccess(0, 16'h1305, 8'h00, 8'h88, 1'b0); // R9 full again
    runAccess(0, 16'h1306, 8'h00, 8'h99, 1'b0); // hit
    @(negedge clk);
    pageMode = 1'b0;
    bOpen = 0;
    @(negedge clk);
    check("R9 psen high once page closed", psenN, 1);
    runAccess(0, 16'h1307, 8'h00, 8'hAA, 1'b0); // R9 full, mode off

    // R10 idle ale modes
    emiReduce = 1'b1;
    aleEnable = 1'b1;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check("R10 emi holds ale high", ale, 1);
    end
    emiReduce = 1'b0;
    aleEnable = 1'b0;
    @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check("R10 ale quiet when disabled", ale, 0);
    end
    aleEnable = 1'b1;
    highs = 0;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      samples[k] = ale;
      if (ale) highs++;
    end
    check("R10 toggle high count", highs, 6);
    for (int k = 0; k < 8; k++)
      check("R10 toggle period", samples[k], samples[k + 8]);
    runAccess(1, 16'hBEEF, 8'h00, 8'h3C, 1'b0); // access with ale enabled

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule